// File: doc/BRIEF.md
# Read-Port Standby and Automatic Sleep Controller

This block manages the power state of a memory read port. It samples the asynchronous chip-enable, pin-reset and output-enable inputs through a short synchronizer chain. From the synchronized pins, an address-stability timer and a busy flag from the program/erase engine, it decides whether the port is active, sleeping, or in one of two standby depths. It drives the data-pin output enable and the data value presented to those pins.

Standby is requested when chip enable and the pin reset are both high. Standby tri-states the data pins whatever output enable does. It is postponed while a program or erase is running, and it is deep or shallow according to a digital qualifier input. Sleep begins on its own once the address has been stable for an access window plus a margin, whatever the control pins do. While asleep, the last read value stays latched on the data outputs. Standby outranks sleep. Every exit from standby waits a full chip-enable access time before the outputs are driven again.

Top module: `rdport_pwr_ctrl`

## Requirements
- R1: While `rst` is high, and on the first sample after it: `dq_oe`, `standby`, `deep_standby` and `sleep` are 0 and `dq_out` is 0.
- R2: When `chip_en_n` and `pin_reset_n` are both high, `standby` becomes 1 on the SYNC_STAGES-th rising edge after the pins change. While `standby` is 1, `dq_oe` is 0 for either level of `out_en_n`.
- R3: `deep_standby` is 1 exactly when `standby` is 1 and `deep_ok` is 1. When `deep_ok` is 0, the standby is the shallow kind and `deep_standby` is 0.
- R4: While `prog_busy` is 1, `standby` stays 0 even when the pins request it. When `prog_busy` drops, `standby` follows at once.
- R5: After `chip_en_n` falls with `pin_reset_n` high, `dq_oe` (with `out_en_n` low) rises on rising edge SYNC_STAGES+T_CE_CYC and not before. The array data is on `dq_out` one edge later.
- R6: `sleep` rises on rising edge T_ACC_CYC+T_MARGIN_CYC+1 after the last address change, for any level of `out_en_n` and with chip enable low.
- R7: While `sleep` is 1 and the current read has been captured, `dq_out` holds its value even if `array_data` changes.
- R8: An address change drops `sleep` on the next rising edge and restarts the stability window. `dq_out` keeps the previous data through edge T_ACC_CYC+1 and shows the new address's data from edge T_ACC_CYC+2. A change on the edge where sleep was about to start prevents it.
- R9: Standby has priority over sleep: `sleep` is 0 whenever `standby` is 1. `sleep` reappears as soon as standby ends if the address window has already elapsed.
- R10: `pin_reset_n` low, once synchronized, forces `sleep` and `dq_oe` to 0 and clears the stability timer. After release, `sleep` returns on rising edge SYNC_STAGES+T_ACC_CYC+T_MARGIN_CYC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_en_n | input | 1 | Chip enable, active low, asynchronous |
| pin_reset_n | input | 1 | Hardware reset pin, active low, asynchronous |
| out_en_n | input | 1 | Output enable, active low, asynchronous |
| addr | input | ADDR_W | Read address, stable relative to `clk` |
| array_data | input | DATA_W | Array read data for the current address |
| deep_ok | input | 1 | Tighter supply condition met, selects deep standby |
| prog_busy | input | 1 | Program or erase in progress |
| dq_oe | output | 1 | Drive enable for the data pins |
| dq_out | output | DATA_W | Latched read data for the data pins |
| standby | output | 1 | Standby state (either depth) |
| deep_standby | output | 1 | Deep standby state |
| sleep | output | 1 | Automatic sleep state |

## Verification
Two functions can fall in the same cycle. The stability timer can saturate on the very edge where standby ends, and an address change can arrive on the edge where sleep was due. The bench leaves the address idle through a long standby and then lowers chip enable; it expects `sleep` in the same sample in which `standby` clears. It also moves the address one sample before sleep was due, expects `sleep` to stay low there, and expects sleep to come back a full window after the new address.

// File: rtl/rdport_pwr_pkg.sv
package rdport_pwr_pkg;

    typedef enum logic [1:0] {
        PWR_ACTIVE     = 2'd0,
        PWR_SLEEP      = 2'd1,
        PWR_STBY_LIGHT = 2'd2,
        PWR_STBY_DEEP  = 2'd3
    } pwr_mode_e;

    typedef struct packed {
        logic ce_n;
        logic rst_n;
        logic oe_n;
    } pin_ctrl_t;

    // Value the synchronizer holds under reset: deselected, pin reset asserted.
    localparam pin_ctrl_t PINS_IDLE = '{ce_n: 1'b1, rst_n: 1'b0, oe_n: 1'b1};

    function automatic int cnt_bits(input int limit);
        return (limit < 1) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/rdport_pin_sync.sv
module rdport_pin_sync
    import rdport_pwr_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  pin_ctrl_t raw,
    output pin_ctrl_t synced
);
    pin_ctrl_t stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= PINS_IDLE;
        end else begin
            stage_q[0] <= raw;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign synced = stage_q[STAGES-1];
endmodule

// File: rtl/rdport_addr_timer.sv
module rdport_addr_timer
    import rdport_pwr_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int THRESH = 4,
    parameter int LIMIT  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic [ADDR_W-1:0] addr,
    output logic              addr_chg,
    output logic              acc_done,
    output logic              full
);
    localparam int CW = cnt_bits(LIMIT);

    logic [ADDR_W-1:0] addr_q;
    logic [CW-1:0]     cnt_q;

    assign addr_chg = (addr != addr_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            cnt_q  <= '0;
        end else begin
            addr_q <= addr;
            if (clear || addr_chg)
                cnt_q <= '0;
            else if (cnt_q != CW'(LIMIT))
                cnt_q <= cnt_q + 1'b1;
        end
    end

    assign acc_done = (cnt_q >= CW'(THRESH));
    assign full     = (cnt_q == CW'(LIMIT));

    AST_ADDR_WAKE: assert property (@(posedge clk) disable iff (rst)
        addr_chg |=> !full); // R8
endmodule

// File: rtl/rdport_ce_timer.sv
module rdport_ce_timer
    import rdport_pwr_pkg::*;
#(
    parameter int T_CE = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    output logic ready
);
    if (T_CE == 0) begin : g_no_wait
        assign ready = enable;
    end else begin : g_wait
        localparam int CW = cnt_bits(T_CE);
        logic [CW-1:0] cnt_q;

        always_ff @(posedge clk) begin
            if (rst || !enable)
                cnt_q <= '0;
            else if (cnt_q != CW'(T_CE))
                cnt_q <= cnt_q + 1'b1;
        end

        assign ready = enable && (cnt_q == CW'(T_CE));

        AST_READY_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
            $rose(ready) |-> $past(enable)); // R5
    end
endmodule

// File: rtl/rdport_read_latch.sv
module rdport_read_latch #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid,
    input  logic              restart,
    input  logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] dq_q,
    output logic              held
);
    logic take;
    assign take = valid && !held;

    always_ff @(posedge clk) begin
        if (rst) begin
            dq_q <= '0;
            held <= 1'b0;
        end else begin
            if (take)
                dq_q <= rd_data;
            if (restart)
                held <= 1'b0;
            else if (take)
                held <= 1'b1;
        end
    end
endmodule

// File: rtl/rdport_pwr_ctrl.sv
module rdport_pwr_ctrl
    import rdport_pwr_pkg::*;
#(
    parameter int ADDR_W       = 4,
    parameter int DATA_W       = 8,
    parameter int SYNC_STAGES  = 2,
    parameter int T_ACC_CYC    = 4,
    parameter int T_MARGIN_CYC = 2,
    parameter int T_CE_CYC     = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chip_en_n,
    input  logic              pin_reset_n,
    input  logic              out_en_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] array_data,
    input  logic              deep_ok,
    input  logic              prog_busy,
    output logic              dq_oe,
    output logic [DATA_W-1:0] dq_out,
    output logic              standby,
    output logic              deep_standby,
    output logic              sleep
);
    localparam int SLEEP_LIMIT = T_ACC_CYC + T_MARGIN_CYC;

    pin_ctrl_t pins_raw, pins_s;
    pwr_mode_e mode;
    logic      addr_chg, acc_done, timer_full;
    logic      ce_ready, rd_valid, held;

    assign pins_raw = '{ce_n: chip_en_n, rst_n: pin_reset_n, oe_n: out_en_n};

    rdport_pin_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk    (clk),
        .rst    (rst),
        .raw    (pins_raw),
        .synced (pins_s)
    );

    rdport_addr_timer #(
        .ADDR_W (ADDR_W),
        .THRESH (T_ACC_CYC),
        .LIMIT  (SLEEP_LIMIT)
    ) timer_i (
        .clk      (clk),
        .rst      (rst),
        .clear    (!pins_s.rst_n),
        .addr     (addr),
        .addr_chg (addr_chg),
        .acc_done (acc_done),
        .full     (timer_full)
    );

    rdport_ce_timer #(.T_CE(T_CE_CYC)) ce_i (
        .clk    (clk),
        .rst    (rst),
        .enable (!pins_s.ce_n && pins_s.rst_n),
        .ready  (ce_ready)
    );

    assign rd_valid = ce_ready && acc_done && !addr_chg;

    rdport_read_latch #(.DATA_W(DATA_W)) latch_i (
        .clk     (clk),
        .rst     (rst),
        .valid   (rd_valid),
        .restart (addr_chg || !ce_ready),
        .rd_data (array_data),
        .dq_q    (dq_out),
        .held    (held)
    );

    // Standby outranks sleep; a running program/erase holds the port active.
    always_comb begin
        if (pins_s.ce_n && pins_s.rst_n && !prog_busy)
            mode = deep_ok ? PWR_STBY_DEEP : PWR_STBY_LIGHT;
        else if (timer_full && pins_s.rst_n)
            mode = PWR_SLEEP;
        else
            mode = PWR_ACTIVE;
    end

    assign standby      = (mode == PWR_STBY_LIGHT) || (mode == PWR_STBY_DEEP);
    assign deep_standby = (mode == PWR_STBY_DEEP);
    assign sleep        = (mode == PWR_SLEEP);
    assign dq_oe        = ce_ready && !pins_s.oe_n;

    AST_STBY_TRISTATE: assert property (@(posedge clk) disable iff (rst)
        standby |-> !dq_oe); // R2
    AST_DEEP_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
        deep_standby |-> (standby && deep_ok)); // R3
    AST_SLEEP_HOLDS_DATA: assert property (@(posedge clk) disable iff (rst)
        (sleep && $past(sleep) && $past(held)) |-> $stable(dq_out)); // R7
    AST_PINRST_CLEARS_SLEEP: assert property (@(posedge clk) disable iff (rst)
        !pins_s.rst_n |=> !sleep); // R10
endmodule

// File: tb/rdport_pwr_ctrl_tb.sv
module rdport_pwr_ctrl_tb_top;
    localparam int AW   = 4;
    localparam int DW   = 8;
    localparam int SYNC = 2;
    localparam int TACC = 4;
    localparam int TMAR = 2;
    localparam int TCE  = 3;
    localparam int LIM  = TACC + TMAR;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          chip_en_n = 1'b1, pin_reset_n = 1'b1, out_en_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] array_data;
    logic [DW-1:0] salt = 8'h5A;
    logic          deep_ok = 1'b0, prog_busy = 1'b0;
    logic          dq_oe, standby, deep_standby, sleep;
    logic [DW-1:0] dq_out;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;
    logic [DW-1:0] prev;

    always #10 clk = ~clk;

    assign array_data = DW'(int'(addr) * 37 + int'(salt));

    function automatic logic [DW-1:0] expect_data(input int a, input logic [DW-1:0] s);
        return DW'(a * 37 + int'(s));
    endfunction

    rdport_pwr_ctrl #(
        .ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(SYNC),
        .T_ACC_CYC(TACC), .T_MARGIN_CYC(TMAR), .T_CE_CYC(TCE)
    ) dut_i (
        .clk(clk), .rst(rst), .chip_en_n(chip_en_n), .pin_reset_n(pin_reset_n),
        .out_en_n(out_en_n), .addr(addr), .array_data(array_data),
        .deep_ok(deep_ok), .prog_busy(prog_busy), .dq_oe(dq_oe), .dq_out(dq_out),
        .standby(standby), .deep_standby(deep_standby), .sleep(sleep)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        tick(3);
        check("R1", "dq_oe in reset", 32'(dq_oe), 0);
        check("R1", "standby in reset", 32'(standby), 0);
        check("R1", "deep in reset", 32'(deep_standby), 0);
        check("R1", "sleep in reset", 32'(sleep), 0);
        check("R1", "dq_out in reset", 32'(dq_out), 0);
        rst = 1'b0;
        out_en_n = 1'b0;
        tick(1);
        check("R1", "standby first sample", 32'(standby), 0);
        check("R2", "standby before sync", 32'(standby), 0);
        tick(SYNC - 1);
        check("R2", "standby after sync", 32'(standby), 1);
        check("R2", "dq_oe off in standby", 32'(dq_oe), 0);
        check("R3", "shallow standby", 32'(deep_standby), 0);
        deep_ok = 1'b1; #1;
        check("R3", "deep standby", 32'(deep_standby), 1);
        deep_ok = 1'b0; #1;
        check("R3", "deep off with qualifier low", 32'(deep_standby), 0);

        tick(10);
        check("R9", "no sleep during standby", 32'(sleep), 0);
        check("R9", "standby held", 32'(standby), 1);

        deep_ok = 1'b1; prog_busy = 1'b1; #1;
        check("R4", "standby deferred by busy", 32'(standby), 0);
        check("R4", "deep deferred by busy", 32'(deep_standby), 0);
        check("R4", "dq_oe still off", 32'(dq_oe), 0);
        prog_busy = 1'b0; #1;
        check("R4", "standby after busy ends", 32'(standby), 1);
        deep_ok = 1'b0;

        // Standby exit with an address long stable: sleep appears as standby clears.
        chip_en_n = 1'b0;
        tick(1);
        check("R2", "standby before sync of exit", 32'(standby), 1);
        tick(SYNC - 1);
        check("R9", "standby cleared", 32'(standby), 0);
        check("R9", "sleep in same sample", 32'(sleep), 1);
        tick(TCE - 1);
        check("R5", "dq_oe before access time", 32'(dq_oe), 0);
        tick(1);
        check("R5", "dq_oe at access time", 32'(dq_oe), 1);
        tick(1);
        check("R5", "data after chip enable", 32'(dq_out), 32'(expect_data(0, 8'h5A)));
        prev = expect_data(0, 8'h5A);

        salt = 8'hC3;
        tick(3);
        check("R7", "sleep held", 32'(sleep), 1);
        check("R7", "latched data unchanged", 32'(dq_out), 32'(prev));

        for (int a = 1; a < (1 << AW); a++) begin
            out_en_n = a[0];
            addr = AW'(a);
            for (int s = 1; s <= LIM + 1; s++) begin
                tick(1);
                if (s == 1) check("R8", "sleep drops on change", 32'(sleep), 0);
                if (s == TACC + 1) check("R8", "old data held", 32'(dq_out), 32'(prev));
                if (s == TACC + 2) check("R8", "new data", 32'(dq_out), 32'(expect_data(a, salt)));
                if (s == LIM) check("R6", "sleep not yet", 32'(sleep), 0);
                if (s == LIM + 1) begin
                    check("R6", "sleep after window", 32'(sleep), 1);
                    check("R6", "dq_oe follows oe", 32'(dq_oe), 32'(!a[0]));
                end
            end
            prev = expect_data(a, salt);
        end
        out_en_n = 1'b0;

        // Address change on the edge where sleep was due.
        addr = 4'd3;
        tick(LIM);
        check("R8", "sleep not yet before race", 32'(sleep), 0);
        addr = 4'd9;
        tick(1);
        check("R8", "sleep suppressed by late change", 32'(sleep), 0);
        tick(LIM - 1);
        check("R8", "sleep still off", 32'(sleep), 0);
        check("R8", "data after race", 32'(dq_out), 32'(expect_data(9, salt)));
        tick(1);
        check("R8", "sleep after restarted window", 32'(sleep), 1);

        // Pin reset.
        pin_reset_n = 1'b0;
        tick(SYNC);
        check("R10", "sleep cleared by pin reset", 32'(sleep), 0);
        check("R10", "dq_oe off in pin reset", 32'(dq_oe), 0);
        tick(3);
        pin_reset_n = 1'b1;
        for (int s = 1; s <= SYNC + LIM; s++) begin
            tick(1);
            if (s == SYNC + TCE - 1) check("R5", "dq_oe before access after reset", 32'(dq_oe), 0);
            if (s == SYNC + TCE) check("R5", "dq_oe after reset release", 32'(dq_oe), 1);
            if (s == SYNC + LIM - 1) check("R10", "sleep not yet after release", 32'(sleep), 0);
            if (s == SYNC + LIM) check("R10", "sleep after full window", 32'(sleep), 1);
        end

        chip_en_n = 1'b1;
        tick(SYNC);
        check("R2", "standby re-entered", 32'(standby), 1);
        check("R2", "dq_oe off with oe low", 32'(dq_oe), 0);
        check("R9", "sleep yields to standby", 32'(sleep), 0);
        check("R3", "shallow again", 32'(deep_standby), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog all-requirements actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule